// File: doc/BRIEF.md
# Return Stack with Interrupt Deferral

This block keeps the return addresses of a small microcontroller core. A subroutine call stores the current program counter, and so does the entry into an interrupt service routine. A return from either one removes the most recent address and presents it to the core as the restored program counter. Storage is a circular buffer of `DEPTH` slots. When the buffer is full and another call arrives, the call overwrites the oldest slot, so the newest `DEPTH` addresses always remain.

The block also decides when an interrupt may be taken. An unmasked request is captured in a pending flag. The acknowledge is issued only while the stack has a free slot. While the stack is full, the request waits. It is acknowledged in the cycle after a return frees a slot. An acknowledge stores `pc_i` in the same cycle, in the same way as a call does.

Top module: `ret_stack_top`

## Requirements
- R1: While reset is asserted and after it is released, `empty_o`=1, `full_o`=0, `irq_ack_o`=0 and `ret_pc_o`=0. All slots are cleared to zero.
- R2: `ret_pc_o` shows the top of the stack without any delay. A return (`ret_i`=1) removes that value, so successive returns give the stored values in the reverse of their push order.
- R3: `full_o` is 1 exactly when `DEPTH` (16) addresses are stored. `empty_o` is 1 exactly when none are stored.
- R4: A push while full overwrites the oldest entry. `full_o` stays 1, and the next 16 returns give the 16 most recent pushes.
- R5: A return on an empty stack leaves the stack empty and the pointer unchanged. It shows the slot below the write pointer (zero after reset). A following push and return then behave normally.
- R6: If `call_i` and `ret_i` are both 1 in one cycle, only the return is performed and the pushed value is dropped.
- R7: When `irq_req_i`=1 and `irq_mask_i`=0, the request is latched at the clock edge. In the next cycle, `irq_ack_o`=1 if the stack is not full, and `pc_i` is pushed in that cycle. The pending flag then clears, so `irq_ack_o` is 0 in the cycle after.
- R8: While `full_o`=1, a latched request keeps `irq_ack_o` at 0 but stays pending.
- R9: When a return leaves a full stack with a free slot, the pending request is acknowledged in the next cycle. Its push refills the stack.
- R10: A request made while `irq_mask_i`=1 is never latched. While `irq_mask_i`=1, no acknowledge is given, even for a request that is already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Push request for a subroutine call |
| pc_i | input | PC_W | Program counter value to store |
| ret_i | input | 1 | Pop request for a return |
| irq_req_i | input | 1 | Interrupt request |
| irq_mask_i | input | 1 | 1 = interrupt masked |
| irq_ack_o | output | 1 | Interrupt acknowledge; stores `pc_i` this cycle |
| ret_pc_o | output | PC_W | Top-of-stack value, the restored program counter |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The bench fills the stack and then pushes beyond full. A design that faulted or stopped at full would return stale or wrong addresses instead of the newest 16. It holds an interrupt pending across a full stack. A design that acknowledged anyway would overflow, and one that forgot the pending flag would never acknowledge after the return. It also covers:
- a return on an empty stack, where a broken count would wrap to full;
- a simultaneous call and return, where the pushed value must not appear;
- masked requests, both new and already pending, which must never produce an acknowledge.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2
  } rstk_op_e;
endpackage

// File: rtl/rstk_mem.sv
module rstk_mem #(
  parameter int DEPTH = 16,
  parameter int PC_W  = 16,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [PTR_W-1:0] wr_idx_i,
  input  logic [PC_W-1:0]  wr_data_i,
  input  logic [PTR_W-1:0] rd_idx_i,
  output logic [PC_W-1:0]  rd_data_o
);
  logic [PC_W-1:0] slot_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) slot_q[i] <= '0;
      else if (we_i && (wr_idx_i == PTR_W'(i))) slot_q[i] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];
endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rstk_op_e         op_i,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_idx_o,
  output logic             full_o,
  output logic             empty_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      unique case (op_i)
        OP_PUSH: begin
          wr_ptr_q <= wr_ptr_q + 1'b1;
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
        end
        OP_POP: begin
          // empty pop: hold pointer and count
          if (cnt_q != '0) begin
            wr_ptr_q <= wr_ptr_q - 1'b1;
            cnt_q    <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_ptr_o = wr_ptr_q;
  assign rd_idx_o = wr_ptr_q - 1'b1;
  assign full_o   = (cnt_q == CNT_MAX);
  assign empty_o  = (cnt_q == '0);

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX); // R3
  AST_FULL_PUSH_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_PUSH && full_o) |=> full_o); // R4
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && empty_o) |=> (empty_o && $stable(wr_ptr_q))); // R5
  AST_POP_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_POP && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2
endmodule

// File: rtl/rstk_irq_gate.sv
module rstk_irq_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic irq_req_i,
  input  logic irq_mask_i,
  input  logic full_i,
  input  logic ret_i,
  output logic ack_o
);
  logic pend_q;

  // ack only with a free slot and no return in the same cycle
  assign ack_o = pend_q && !irq_mask_i && !full_i && !ret_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q && !ack_o) || (irq_req_i && !irq_mask_i);
  end

  AST_NO_ACK_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !full_i); // R8
  AST_NO_ACK_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !irq_mask_i); // R10
  AST_PEND_HELD_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && full_i) |=> pend_q); // R8
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !irq_req_i) |=> !ack_o); // R7
endmodule

// File: rtl/ret_stack_top.sv
module ret_stack_top
  import rstk_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            call_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            ret_i,
  input  logic            irq_req_i,
  input  logic            irq_mask_i,
  output logic            irq_ack_o,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic             ack;
  logic             push;
  rstk_op_e         op;
  logic [PTR_W-1:0] wr_ptr;
  logic [PTR_W-1:0] rd_idx;

  // pop wins over push
  assign push = (call_i || ack) && !ret_i;
  always_comb begin
    if (ret_i)     op = OP_POP;
    else if (push) op = OP_PUSH;
    else           op = OP_NONE;
  end

  rstk_irq_gate u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .irq_req_i  (irq_req_i),
    .irq_mask_i (irq_mask_i),
    .full_i     (full_o),
    .ret_i      (ret_i),
    .ack_o      (ack)
  );

  rstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .op_i     (op),
    .wr_ptr_o (wr_ptr),
    .rd_idx_o (rd_idx),
    .full_o   (full_o),
    .empty_o  (empty_o)
  );

  rstk_mem #(.DEPTH(DEPTH), .PC_W(PC_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (op == OP_PUSH),
    .wr_idx_i  (wr_ptr),
    .wr_data_i (pc_i),
    .rd_idx_i  (rd_idx),
    .rd_data_o (ret_pc_o)
  );

  assign irq_ack_o = ack;

  AST_SAME_CYCLE_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (call_i && ret_i && !empty_o) |=> !full_o); // R6
  AST_ACK_NOT_ON_RET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ack_o |-> !ret_i); // R9
endmodule

// File: tb/ret_stack_top_tb.sv
module ret_stack_top_tb;
  localparam int DEPTH = 16;
  localparam int PC_W  = 16;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic            call_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic            ret_i = 1'b0;
  logic            irq_req_i = 1'b0;
  logic            irq_mask_i = 1'b0;
  logic            irq_ack_o;
  logic [PC_W-1:0] ret_pc_o;
  logic            full_o;
  logic            empty_o;

  int checks = 0;
  int errors = 0;

  logic [PC_W-1:0] mdl[$];
  logic [PC_W-1:0] exp_q[$];
  string           tag_q[$];

  always #2.5 clk = ~clk;

  ret_stack_top #(.DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .call_i(call_i), .pc_i(pc_i), .ret_i(ret_i),
    .irq_req_i(irq_req_i), .irq_mask_i(irq_mask_i), .irq_ack_o(irq_ack_o),
    .ret_pc_o(ret_pc_o), .full_o(full_o), .empty_o(empty_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compare popped value against scoreboard
  always @(negedge clk) begin
    if (rst_ni && ret_i && exp_q.size() > 0) begin
      logic [PC_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, 32'(ret_pc_o), 32'(e));
    end
  end

  // driver: one cycle of stimulus, updates the reference model
  task automatic cycle(input logic c, input logic r, input logic [PC_W-1:0] pc,
                       input logic req, input logic msk, input logic ackx,
                       input string tag, input logic [PC_W-1:0] empty_val);
    @(posedge clk); #1;
    call_i = c; ret_i = r; pc_i = pc; irq_req_i = req; irq_mask_i = msk;
    if (r) begin
      if (mdl.size() > 0) exp_q.push_back(mdl.pop_back());
      else                exp_q.push_back(empty_val);
      tag_q.push_back(tag);
    end else if (c || ackx) begin
      if (mdl.size() == DEPTH) void'(mdl.pop_front());
      mdl.push_back(pc);
    end
    @(negedge clk);
  endtask

  task automatic idle();
    cycle(0, 0, '0, 0, 0, 0, "", '0);
  endtask
  task automatic push(input logic [PC_W-1:0] v);
    cycle(1, 0, v, 0, 0, 0, "", '0);
  endtask
  task automatic pop(input string tag);
    cycle(0, 1, '0, 0, 0, 0, tag, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 full", 32'(full_o), 0);
    chk("R1 ack", 32'(irq_ack_o), 0);
    chk("R1 ret_pc", 32'(ret_pc_o), 0);
    rst_ni = 1'b1;
    idle();
    chk("R1 empty after release", 32'(empty_o), 1);

    // R5: empty pop
    pop("R5 empty pop value");
    idle();
    chk("R5 still empty", 32'(empty_o), 1);
    chk("R5 not full", 32'(full_o), 0);
    push(16'h1234);
    pop("R5 pop after empty pop");
    idle();
    chk("R5 empty again", 32'(empty_o), 1);

    // R2: LIFO order
    push(16'h0011); push(16'h0022); push(16'h0033);
    idle();
    chk("R2 not empty", 32'(empty_o), 0);
    chk("R2 top visible", 32'(ret_pc_o), 32'h0033);
    pop("R2 pop 1"); pop("R2 pop 2"); pop("R2 pop 3");
    idle();
    chk("R2 empty after drain", 32'(empty_o), 1);

    // R6: push and pop together
    push(16'h00A1); push(16'h00B2);
    cycle(1, 1, 16'h00C3, 0, 0, 0, "R6 pop wins", '0);
    pop("R6 next pop");
    idle();
    chk("R6 empty", 32'(empty_o), 1);

    // R3 / R4: fill and overflow
    for (int i = 0; i < DEPTH - 1; i++) push(16'h0100 + 16'(i));
    idle();
    chk("R3 not full at 15", 32'(full_o), 0);
    push(16'h010F);
    idle();
    chk("R3 full at 16", 32'(full_o), 1);
    push(16'h0200);
    push(16'h0201);
    idle();
    chk("R4 full stays", 32'(full_o), 1);
    chk("R4 newest on top", 32'(ret_pc_o), 32'h0201);
    for (int i = 0; i < DEPTH; i++) pop("R4 drain after overwrite");
    idle();
    chk("R3 empty after 16 pops", 32'(empty_o), 1);

    // R7: interrupt acknowledge with room
    cycle(0, 0, '0, 1, 0, 0, "", '0);
    chk("R7 no ack in request cycle", 32'(irq_ack_o), 0);
    cycle(0, 0, 16'h0AA0, 0, 0, 1, "", '0);
    chk("R7 ack", 32'(irq_ack_o), 1);
    idle();
    chk("R7 pending cleared", 32'(irq_ack_o), 0);
    chk("R7 ack pushed", 32'(empty_o), 0);
    pop("R7 ack pushed pc");

    // R8 / R9: deferral while full
    for (int i = 0; i < DEPTH; i++) push(16'h0300 + 16'(i));
    cycle(0, 0, '0, 1, 0, 0, "", '0);
    chk("R8 no ack while full", 32'(irq_ack_o), 0);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R8 ack held while full", 32'(irq_ack_o), 0);
    end
    pop("R8 pop frees slot");
    chk("R8 no ack during ret", 32'(irq_ack_o), 0);
    cycle(0, 0, 16'h0BB0, 0, 0, 1, "", '0);
    chk("R9 ack after room", 32'(irq_ack_o), 1);
    idle();
    chk("R9 ack single", 32'(irq_ack_o), 0);
    chk("R9 refilled", 32'(full_o), 1);
    for (int i = 0; i < DEPTH; i++) pop("R9 drain");
    idle();
    chk("R9 empty", 32'(empty_o), 1);

    // R10: masking
    cycle(0, 0, '0, 1, 1, 0, "", '0);
    chk("R10 masked req no ack", 32'(irq_ack_o), 0);
    for (int i = 0; i < 3; i++) begin
      idle();
      chk("R10 masked req not latched", 32'(irq_ack_o), 0);
    end
    chk("R10 no push", 32'(empty_o), 1);
    cycle(0, 0, '0, 1, 0, 0, "", '0);
    cycle(0, 0, 16'h0CC0, 0, 1, 0, "", '0);
    chk("R10 pending masked no ack", 32'(irq_ack_o), 0);
    cycle(0, 0, 16'h0CC0, 0, 0, 1, "", '0);
    chk("R10 ack after unmask", 32'(irq_ack_o), 1);
    pop("R10 pushed pc");
    idle();
    chk("R10 empty", 32'(empty_o), 1);
    chk("scoreboard drained", 32'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule